// File: doc/BRIEF.md
# Vector Length Setting Unit

This block holds the per-register vector configuration for both register files of a core: every integer and every floating-point register has a 4-bit vector length and a 3-bit element-width code. Software loads these entries through a configuration write port. The instruction decoder reads a one-bit-per-register flag that marks each register as a vector or a scalar.

The block also runs the set-vector-length operation. A strobe names a register file, a source register and a requested length. The unit finds the number of SIMD sub-elements that fit in one register of that configuration. It multiplies the configured length by that number, limits the product to XLEN, and then limits it to the requested value. The result is stored as the active vector length, which is read back on an output port. If the configuration is illegal, the unit raises a flag and keeps the previous active length.

Top module: `vlen_set_unit`

## Requirements
- R1: After reset the active length is 0, the done and illegal outputs are 0, and every configured length is 0, so both vector masks read all zeros.
- R2: The element-width code gives the bytes per element. Code 000 is XLEN/8 bytes, and codes 001, 010, 011, 100 and 101 are 1, 2, 4, 8 and 16 bytes. The sub-element multiplier is (XLEN/8) divided by the bytes per element.
- R3: A legal set operation stores min(min(length x multiplier, XLEN), requested) as the active length.
- R4: A configured length of 0 counts as one element with a multiplier of 1. Its width code is ignored, even a reserved one, and it never raises the illegal flag.
- R5: If the configured length is nonzero and the width code is 110 or 111, or selects an element wider than XLEN bits, the set operation raises the illegal flag and leaves the active length unchanged.
- R6: The done output pulses for exactly one cycle, in the cycle after each set strobe. The active length changes only in that cycle, and the illegal flag is only raised together with done.
- R7: Bit n of a file's vector mask is 1 exactly when register n of that file has a nonzero length. The mask reflects a configuration write from the cycle after that write.
- R8: The integer file (select 0) and the floating-point file (select 1) hold separate tables. A configuration write touches only the selected file, and a set operation reads only the file it selects.
- R9: The active length never exceeds XLEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fp | input | 1 | Configuration file select (0 integer, 1 floating point) |
| cfg_idx | input | $clog2(NREG) | Register being configured |
| cfg_len | input | 4 | Vector length to store |
| cfg_ew | input | 3 | Element-width code to store |
| set_req | input | 1 | Set-vector-length strobe |
| set_fp | input | 1 | File select for the set operation |
| set_idx | input | $clog2(NREG) | Source register whose configuration is used |
| set_rqlen | input | XLEN | Requested length |
| vl_out | output | $clog2(XLEN)+1 | Active vector length |
| set_done | output | 1 | One-cycle completion pulse |
| cfg_illegal | output | 1 | Illegal-configuration pulse, given with done |
| int_vec_mask | output | NREG | Vector flag per integer register |
| fp_vec_mask | output | NREG | Vector flag per floating-point register |

## Verification
Each result has a fixed due cycle. The active length, done and illegal pulses belong to the rising edge that captures the set strobe, and a mask bit belongs to the edge that captures its configuration write. The bench changes inputs on the falling edge and samples on the next falling edge, so every check reads an output exactly one register stage after its stimulus. A further falling-edge sample confirms that done has dropped and that the active length holds.

// File: rtl/vlen_set_unit.sv
module vlen_set_unit #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic                      cfg_fp,
  input  logic [$clog2(NREG)-1:0]   cfg_idx,
  input  logic [3:0]                cfg_len,
  input  logic [2:0]                cfg_ew,
  input  logic                      set_req,
  input  logic                      set_fp,
  input  logic [$clog2(NREG)-1:0]   set_idx,
  input  logic [XLEN-1:0]           set_rqlen,
  output logic [$clog2(XLEN):0]     vl_out,
  output logic                      set_done,
  output logic                      cfg_illegal,
  output logic [NREG-1:0]           int_vec_mask,
  output logic [NREG-1:0]           fp_vec_mask
);
  localparam int LW  = $clog2(XLEN) + 1;
  localparam int BL  = $clog2(XLEN / 8);
  localparam int PW  = 4 + BL + 1;
  localparam logic [2:0] BLV = 3'(BL);

  logic [3:0] len_q [2][NREG];
  logic [2:0] ew_q  [2][NREG];

  logic [3:0] s_len;
  logic [2:0] s_ew;
  logic [2:0] sh;
  logic       bad;
  logic [PW-1:0]   prod, clamp1;
  logic [XLEN-1:0] clamp1x, nxt;

  assign s_len = len_q[set_fp][set_idx];
  assign s_ew  = ew_q[set_fp][set_idx];

  always_comb begin
    bad = 1'b0;
    sh  = 3'd0;
    if (s_len != 4'd0 && s_ew != 3'd0) begin
      if (s_ew > 3'd5 || (s_ew - 3'd1) > BLV) bad = 1'b1;
      else sh = BLV - (s_ew - 3'd1);
    end
  end

  assign prod    = PW'((s_len == 4'd0) ? 4'd1 : s_len) << sh;
  assign clamp1  = (prod > PW'(XLEN)) ? PW'(XLEN) : prod;
  assign clamp1x = XLEN'(clamp1);
  assign nxt     = (set_rqlen < clamp1x) ? set_rqlen : clamp1x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < 2; f++)
        for (int r = 0; r < NREG; r++) begin
          len_q[f][r] <= '0;
          ew_q[f][r]  <= '0;
        end
      vl_out      <= '0;
      set_done    <= 1'b0;
      cfg_illegal <= 1'b0;
    end else begin
      if (cfg_we) begin
        len_q[cfg_fp][cfg_idx] <= cfg_len;
        ew_q[cfg_fp][cfg_idx]  <= cfg_ew;
      end
      set_done    <= set_req;
      cfg_illegal <= set_req & bad;
      if (set_req && !bad) vl_out <= nxt[LW-1:0];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_mask
    assign int_vec_mask[g] = |len_q[0][g];
    assign fp_vec_mask[g]  = |len_q[1][g];
  end

  // R6
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> set_done);
  // R6
  done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |-> $past(set_req));
  // R6
  vl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_done |-> $stable(vl_out));
  // R5
  illegal_keeps_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> (set_done && $stable(vl_out)));
  // R9
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_out <= LW'(XLEN));
  // R4
  zero_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && s_len == 4'd0) |=> !cfg_illegal);
endmodule

// File: tb/tb_vlen_set_unit.sv
module tb_vlen_set_unit;
  localparam int XLEN = 32;
  localparam int NREG = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_fp = 1'b0;
  logic [4:0] cfg_idx = '0;
  logic [3:0] cfg_len = '0;
  logic [2:0] cfg_ew = '0;
  logic set_req = 1'b0, set_fp = 1'b0;
  logic [4:0] set_idx = '0;
  logic [XLEN-1:0] set_rqlen = '0;
  logic [5:0] vl_out;
  logic set_done, cfg_illegal;
  logic [NREG-1:0] int_vec_mask, fp_vec_mask;

  int errors = 0, checks = 0;

  vlen_set_unit #(.XLEN(XLEN), .NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fp(cfg_fp),
    .cfg_idx(cfg_idx), .cfg_len(cfg_len), .cfg_ew(cfg_ew),
    .set_req(set_req), .set_fp(set_fp), .set_idx(set_idx),
    .set_rqlen(set_rqlen), .vl_out(vl_out), .set_done(set_done),
    .cfg_illegal(cfg_illegal), .int_vec_mask(int_vec_mask),
    .fp_vec_mask(fp_vec_mask));

  always #2 clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic fp, int idx, int len, int ew);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fp = fp; cfg_idx = 5'(idx);
    cfg_len = 4'(len); cfg_ew = 3'(ew);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_set(string req, logic fp, int idx, int rq, int exp_vl, logic exp_ill);
    @(negedge clk);
    set_req = 1'b1; set_fp = fp; set_idx = 5'(idx); set_rqlen = XLEN'(rq);
    @(negedge clk);
    set_req = 1'b0;
    check({req, " done"}, set_done, 1);
    check({req, " illegal"}, cfg_illegal, exp_ill);
    check({req, " vl"}, vl_out, exp_vl);
    @(negedge clk);
    check("R6 done single pulse", set_done, 0);
    check("R6 vl holds", vl_out, exp_vl);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 vl", vl_out, 0);
    check("R1 done", set_done, 0);
    check("R1 illegal", cfg_illegal, 0);
    check("R1 int mask", int_vec_mask, 0);
    check("R1 fp mask", fp_vec_mask, 0);
  endtask

  task automatic t_default_width();
    write_cfg(0, 3, 2, 0);
    run_set("R2 R3 default width", 0, 3, 10, 2, 0);
  endtask

  task automatic t_byte_width();
    write_cfg(0, 4, 3, 1);
    run_set("R2 R3 8-bit x4", 0, 4, 100, 12, 0);
    run_set("R3 clamp to request", 0, 4, 5, 5, 0);
    write_cfg(0, 7, 1, 2);
    run_set("R2 16-bit scalar x2", 0, 7, 9, 2, 0);
  endtask

  task automatic t_maxdepth();
    write_cfg(0, 5, 15, 1);
    run_set("R9 R3 clamp to XLEN", 0, 5, 40, 32, 0);
    run_set("R3 request zero", 0, 5, 0, 0, 0);
  endtask

  task automatic t_zero_len();
    write_cfg(0, 6, 0, 7);
    run_set("R4 zero length ignores width", 0, 6, 9, 1, 0);
  endtask

  task automatic t_illegal();
    write_cfg(0, 8, 2, 4);
    run_set("R5 too wide keeps vl", 0, 8, 20, 1, 1);
    write_cfg(0, 9, 1, 6);
    run_set("R5 reserved keeps vl", 0, 9, 20, 1, 1);
  endtask

  task automatic t_files();
    write_cfg(1, 3, 4, 3);
    run_set("R8 fp table", 1, 3, 31, 4, 0);
    run_set("R8 int table untouched", 0, 3, 31, 2, 0);
    @(negedge clk);
    check("R7 R8 fp mask", fp_vec_mask, 32'h0000_0008);
    check("R7 int mask", int_vec_mask, 32'h0000_03B8);
  endtask

  task automatic t_idle();
    write_cfg(0, 3, 0, 0);
    check("R7 mask clears after write", int_vec_mask, 32'h0000_03B0);
    check("R6 cfg write no done", set_done, 0);
    check("R6 cfg write keeps vl", vl_out, 2);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_width();
    t_byte_width();
    t_maxdepth();
    t_zero_len();
    t_illegal();
    t_files();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule